// File: doc/BRIEF.md
# Packed Integer Dot-Product Accumulator

This block is a pipelined integer datapath that folds a short dot product into a running 32-bit sum. Each operation presents two packed 32-bit operands and a 32-bit accumulator value. It returns `acc + sum(x_i * y_i)` two clock cycles later. One operation can be accepted on every cycle.

Two modes share the same multipliers and adder tree:
- **Quad mode** splits both operands into four bytes and forms four 8x8 products.
- **Pair mode** takes two 16-bit elements from the first operand. It takes two bytes from one selected half of the second operand and forms two 16x8 products.

A separate control bit for each operand picks signed or unsigned interpretation of its elements. This allows signed, unsigned and mixed-sign products.

All control bits are captured together with the operands and move down the pipeline with them. A stream can therefore switch mode, half selection or signedness on every cycle. The final sum wraps modulo 2^32. The block has no saturation and no overflow indication.

Top module: `pkdot_unit`

## Requirements
- R1: With `in_mode`=0 (quad), the result is `in_acc` plus the sum over i=0..3 of A byte i times B byte i. Byte i occupies bits [8i+7:8i] of each operand, so lane 0 is the least significant byte.
- R2: With `in_mode`=1 (pair), A halfword i (bits [16i+15:16i], i=0..1) is multiplied by selected byte i. The two products are summed and added to `in_acc`. When `in_half_sel`=0 the selected bytes are B[7:0] and B[15:8]; when `in_half_sel`=1 they are B[23:16] and B[31:24]. The unselected half of B has no effect on the result.
- R3: `in_a_signed`=1 sign-extends every A element and 0 zero-extends it. `in_b_signed` does the same for B elements. The two controls act independently.
- R4: The final addition wraps modulo 2^32.
- R5: `out_valid` is high exactly two rising edges after an edge at which `in_valid` and `in_ready` were both high. The matching `out_result` is present in that same cycle.
- R6: Operations accepted on consecutive cycles each produce their own correct result on consecutive cycles, even when mode, half selection and signedness differ between neighbours.
- R7: While `rst` is high, `in_ready` and `out_valid` are 0 and `out_result` is 0. `in_ready` is 1 from the first cycle after the first rising edge with `rst` low.
- R8: With `in_valid` low, no result is produced, and `out_result` keeps its last value whatever the data inputs carry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation present on the inputs |
| in_ready | output | 1 | Block accepts an operation this cycle |
| in_a | input | 32 | Packed operand A (bytes or halfwords) |
| in_b | input | 32 | Packed operand B (bytes) |
| in_acc | input | 32 | Accumulator addend |
| in_mode | input | 1 | 0 = four 8x8 lanes, 1 = two 16x8 lanes |
| in_half_sel | input | 1 | Pair mode: 0 = low half of B, 1 = high half of B |
| in_a_signed | input | 1 | A elements signed when 1 |
| in_b_signed | input | 1 | B elements signed when 1 |
| out_valid | output | 1 | Result valid this cycle |
| out_result | output | 32 | Accumulated dot product |

## Verification
Every result is due two rising edges after the edge that accepts its operation: one edge loads the product register and the next loads the sum. The bench changes inputs on falling edges and samples outputs on falling edges. The result for an operation driven at falling edge n is therefore read at falling edge n+2. The vector stream is walked with that two-step lag, so neighbouring operations with different controls overlap inside the pipeline. The directed tests confirm that `out_valid` stays low one cycle after acceptance, rises on the second, and drops again once the pipeline has drained.

// File: rtl/pkdot_pkg.sv
package pkdot_pkg;
    localparam int WORD_W     = 32;
    localparam int BYTE_W     = 8;
    localparam int HALF_W     = 16;
    localparam int LANES      = WORD_W / BYTE_W;
    localparam int PAIR_LANES = WORD_W / HALF_W;
    localparam int EA_W       = HALF_W + 1;       // widest A element plus sign room
    localparam int EB_W       = BYTE_W + 1;       // B element plus sign room
    localparam int PROD_W     = EA_W + EB_W;

    typedef enum logic {
        MODE_QUAD = 1'b0,
        MODE_PAIR = 1'b1
    } dot_mode_e;

    typedef struct packed {
        dot_mode_e mode;
        logic      half_sel;
        logic      a_signed;
        logic      b_signed;
    } dot_ctrl_t;

    typedef logic signed [PROD_W-1:0] prod_t;
    typedef logic [LANES-1:0][EA_W-1:0]   a_lanes_t;
    typedef logic [LANES-1:0][EB_W-1:0]   b_lanes_t;
    typedef logic [LANES-1:0][PROD_W-1:0] prod_lanes_t;

    // byte widened to the B element width
    function automatic logic [EB_W-1:0] widen_byte(input logic [BYTE_W-1:0] v, input logic sgn);
        return {sgn & v[BYTE_W-1], v};
    endfunction

    // byte widened to the A element width
    function automatic logic [EA_W-1:0] widen_byte_a(input logic [BYTE_W-1:0] v, input logic sgn);
        return {{(EA_W-BYTE_W){sgn & v[BYTE_W-1]}}, v};
    endfunction

    // halfword widened to the A element width
    function automatic logic [EA_W-1:0] widen_half(input logic [HALF_W-1:0] v, input logic sgn);
        return {sgn & v[HALF_W-1], v};
    endfunction
endpackage

// File: rtl/pkdot_unpack.sv
module pkdot_unpack
    import pkdot_pkg::*;
(
    input  logic [WORD_W-1:0] a,
    input  logic [WORD_W-1:0] b,
    input  dot_ctrl_t         ctrl,
    output a_lanes_t          a_el,
    output b_lanes_t          b_el
);
    logic [HALF_W-1:0] b_half;

    assign b_half = ctrl.half_sel ? b[WORD_W-1 -: HALF_W] : b[HALF_W-1:0];

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic [EA_W-1:0] quad_a;
        logic [EB_W-1:0] quad_b;
        logic [EA_W-1:0] pair_a;
        logic [EB_W-1:0] pair_b;

        assign quad_a = widen_byte_a(a[i*BYTE_W +: BYTE_W], ctrl.a_signed);
        assign quad_b = widen_byte(b[i*BYTE_W +: BYTE_W], ctrl.b_signed);

        if (i < PAIR_LANES) begin : g_pair
            assign pair_a = widen_half(a[i*HALF_W +: HALF_W], ctrl.a_signed);
            assign pair_b = widen_byte(b_half[i*BYTE_W +: BYTE_W], ctrl.b_signed);
        end else begin : g_idle
            assign pair_a = '0;
            assign pair_b = '0;
        end

        assign a_el[i] = (ctrl.mode == MODE_PAIR) ? pair_a : quad_a;
        assign b_el[i] = (ctrl.mode == MODE_PAIR) ? pair_b : quad_b;
    end
endmodule

// File: rtl/pkdot_mul_stage.sv
module pkdot_mul_stage
    import pkdot_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              fire,
    input  dot_ctrl_t         ctrl_in,
    input  logic [WORD_W-1:0] acc_in,
    input  a_lanes_t          a_el,
    input  b_lanes_t          b_el,
    output logic              s1_valid,
    output dot_ctrl_t         s1_ctrl,
    output logic [WORD_W-1:0] s1_acc,
    output prod_lanes_t       s1_prod
);
    prod_lanes_t prod_d;

    for (genvar i = 0; i < LANES; i++) begin : g_mul
        prod_t pa;
        prod_t pb;
        prod_t pp;
        assign pa = prod_t'($signed(a_el[i]));
        assign pb = prod_t'($signed(b_el[i]));
        assign pp = pa * pb;
        assign prod_d[i] = pp;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_valid <= 1'b0;
            s1_ctrl  <= '0;
            s1_acc   <= '0;
            s1_prod  <= '0;
        end else begin
            s1_valid <= fire;
            if (fire) begin
                s1_ctrl <= ctrl_in;
                s1_acc  <= acc_in;
                s1_prod <= prod_d;
            end
        end
    end

    // upper lanes must carry nothing in pair mode
    AST_PAIR_UPPER_IDLE: assert property (@(posedge clk) disable iff (rst)
        (s1_valid && s1_ctrl.mode == MODE_PAIR) |-> (s1_prod[2] == '0 && s1_prod[3] == '0)); // R2

    // unsigned-by-unsigned never yields a negative product
    AST_UNSIGNED_NONNEG: assert property (@(posedge clk) disable iff (rst)
        (s1_valid && !s1_ctrl.a_signed && !s1_ctrl.b_signed) |->
        !(s1_prod[0][PROD_W-1] | s1_prod[1][PROD_W-1] | s1_prod[2][PROD_W-1] | s1_prod[3][PROD_W-1])); // R3
endmodule

// File: rtl/pkdot_reduce.sv
module pkdot_reduce
    import pkdot_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              s1_valid,
    input  logic [WORD_W-1:0] s1_acc,
    input  prod_lanes_t       s1_prod,
    output logic              out_valid,
    output logic [WORD_W-1:0] out_result
);
    logic [WORD_W-1:0] sum_d;

    always_comb begin
        sum_d = s1_acc;
        for (int i = 0; i < LANES; i++) begin
            sum_d = sum_d + WORD_W'($signed(s1_prod[i]));
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid  <= 1'b0;
            out_result <= '0;
        end else begin
            out_valid <= s1_valid;
            if (s1_valid) begin
                out_result <= sum_d;
            end
        end
    end

    AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
        !s1_valid |=> $stable(out_result)); // R8

    AST_VALID_FOLLOWS_STAGE1: assert property (@(posedge clk) disable iff (rst)
        s1_valid |=> out_valid); // R5
endmodule

// File: rtl/pkdot_unit.sv
module pkdot_unit
    import pkdot_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        in_valid,
    output logic        in_ready,
    input  logic [31:0] in_a,
    input  logic [31:0] in_b,
    input  logic [31:0] in_acc,
    input  logic        in_mode,
    input  logic        in_half_sel,
    input  logic        in_a_signed,
    input  logic        in_b_signed,
    output logic        out_valid,
    output logic [31:0] out_result
);
    logic        ready_q;
    logic        fire;
    dot_ctrl_t   ctrl_in;
    a_lanes_t    a_el;
    b_lanes_t    b_el;
    logic        s1_valid;
    dot_ctrl_t   s1_ctrl;
    logic [WORD_W-1:0] s1_acc;
    prod_lanes_t s1_prod;

    always_ff @(posedge clk) begin
        if (rst) ready_q <= 1'b0;
        else     ready_q <= 1'b1;
    end

    assign in_ready = ready_q;
    assign fire     = in_valid & ready_q;

    assign ctrl_in.mode     = dot_mode_e'(in_mode);
    assign ctrl_in.half_sel = in_half_sel;
    assign ctrl_in.a_signed = in_a_signed;
    assign ctrl_in.b_signed = in_b_signed;

    pkdot_unpack u_unpack (
        .a    (in_a),
        .b    (in_b),
        .ctrl (ctrl_in),
        .a_el (a_el),
        .b_el (b_el)
    );

    pkdot_mul_stage u_mul (
        .clk      (clk),
        .rst      (rst),
        .fire     (fire),
        .ctrl_in  (ctrl_in),
        .acc_in   (in_acc),
        .a_el     (a_el),
        .b_el     (b_el),
        .s1_valid (s1_valid),
        .s1_ctrl  (s1_ctrl),
        .s1_acc   (s1_acc),
        .s1_prod  (s1_prod)
    );

    pkdot_reduce u_red (
        .clk        (clk),
        .rst        (rst),
        .s1_valid   (s1_valid),
        .s1_acc     (s1_acc),
        .s1_prod    (s1_prod),
        .out_valid  (out_valid),
        .out_result (out_result)
    );

    AST_LATENCY_TWO: assert property (@(posedge clk) disable iff (rst)
        out_valid == $past(fire, 2)); // R5

    AST_READY_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> in_ready); // R7

    AST_CTRL_TRAVELS: assert property (@(posedge clk) disable iff (rst)
        fire |=> (s1_ctrl == $past(ctrl_in))); // R6
endmodule

// File: tb/sim_pkdot_unit.sv
module sim_pkdot_unit;
    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic        in_ready;
    logic [31:0] in_a, in_b, in_acc;
    logic        in_mode, in_half_sel, in_a_signed, in_b_signed;
    logic        out_valid;
    logic [31:0] out_result;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    pkdot_unit u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_a(in_a), .in_b(in_b), .in_acc(in_acc), .in_mode(in_mode),
        .in_half_sel(in_half_sel), .in_a_signed(in_a_signed), .in_b_signed(in_b_signed),
        .out_valid(out_valid), .out_result(out_result)
    );

    // control nibble: {mode, half_sel, a_signed, b_signed}
    localparam int NV = 13;
    localparam logic [31:0] VA [NV] = '{
        32'h04030201, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'h000000FF, 32'h000000FF,
        32'h00030002, 32'h00030002, 32'hFFFF8000, 32'h0000FFFF, 32'h000000FF,
        32'h00000080, 32'h7FFF7FFF, 32'h00010001};
    localparam logic [31:0] VB [NV] = '{
        32'h01010101, 32'h02020202, 32'h02020202, 32'h000000FF, 32'h000000FF,
        32'h00000504, 32'h07060000, 32'h0000FF80, 32'h000000FF, 32'h000000FF,
        32'h00000001, 32'h7F7F0000, 32'h0000FFFF};
    localparam logic [31:0] VACC [NV] = '{
        32'h0, 32'd100, 32'h0, 32'h0, 32'h0,
        32'h10, 32'h0, 32'h0, 32'h0, 32'hFFFFFFFF,
        32'h80000000, 32'h0, 32'd5};
    localparam logic [3:0] VCTL [NV] = '{
        4'b0000, 4'b0011, 4'b0000, 4'b0010, 4'b0001,
        4'b1000, 4'b1100, 4'b1011, 4'b1001, 4'b0000,
        4'b0011, 4'b1111, 4'b1100};
    localparam logic [31:0] VEXP [NV] = '{
        32'h0000000A, 32'h0000005C, 32'h000007F8, 32'hFFFFFF01, 32'hFFFFFF01,
        32'h00000027, 32'h00000021, 32'h00400001, 32'hFFFF0001, 32'h0000FE00,
        32'h7FFFFF80, 32'h007EFF02, 32'h00000005};
    // tags: 0-4 R1/R3 quad, 5-8,11,12 R2/R3 pair (12: unselected half ignored), 9-10 R4 wrap
    localparam string VTAG [NV] = '{
        "R1 quad unsigned", "R3 quad signed", "R3 quad unsigned 255", "R3 quad A signed",
        "R3 quad B signed", "R2 pair low half", "R2 pair high half", "R3 pair signed",
        "R3 pair mixed", "R4 wrap up", "R4 wrap signed", "R2 pair high signed",
        "R2 pair low half ignored"};

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic drive(input logic v, input logic [31:0] a, input logic [31:0] b,
                         input logic [31:0] acc, input logic [3:0] c);
        in_valid    = v;
        in_a        = a;
        in_b        = b;
        in_acc      = acc;
        in_mode     = c[3];
        in_half_sel = c[2];
        in_a_signed = c[1];
        in_b_signed = c[0];
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        drive(1'b1, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'h12345678, 4'b0000);
        repeat (3) @(negedge clk);
        // R7 reset state
        check("R7 ready in reset", {31'b0, in_ready}, 32'd0);
        check("R7 valid in reset", {31'b0, out_valid}, 32'd0);
        check("R7 result in reset", out_result, 32'd0);
        rst = 1'b0;
        drive(1'b0, 32'h0, 32'h0, 32'h0, 4'b0000);
        @(negedge clk);
        check("R7 ready after reset", {31'b0, in_ready}, 32'd1);
        check("R7 no output after reset", {31'b0, out_valid}, 32'd0);

        // vector stream, back to back, R6: each result two steps after its drive
        for (int i = 0; i < NV + 2; i++) begin
            if (i >= 2) begin
                check({VTAG[i-2], " R6 valid"}, {31'b0, out_valid}, 32'd1);
                check({VTAG[i-2], " R6"}, out_result, VEXP[i-2]);
            end
            if (i < NV) drive(1'b1, VA[i], VB[i], VACC[i], VCTL[i]);
            else        drive(1'b0, 32'h0, 32'h0, 32'h0, 4'b0000);
            @(negedge clk);
        end
        check("R5 drained", {31'b0, out_valid}, 32'd0);

        // R5 isolated latency
        drive(1'b1, 32'h04030201, 32'h01010101, 32'h0, 4'b0000);
        @(negedge clk);
        drive(1'b0, 32'hDEADBEEF, 32'hCAFEF00D, 32'h11111111, 4'b1111);
        check("R5 not yet valid", {31'b0, out_valid}, 32'd0);
        @(negedge clk);
        check("R5 valid at two", {31'b0, out_valid}, 32'd1);
        check("R5 result at two", out_result, 32'h0000000A);

        // R8 idle inputs produce nothing and result holds
        for (int k = 0; k < 4; k++) begin
            drive(1'b0, 32'hA5A5A5A5 ^ k, 32'h5A5A5A5A, 32'h00000F00, 4'(k));
            @(negedge clk);
            check("R8 no output when idle", {31'b0, out_valid}, 32'd0);
            check("R8 result held", out_result, 32'h0000000A);
        end

        // R2 unselected half ignored, isolated
        drive(1'b1, 32'h00020001, 32'hFFFF0302, 32'h0, 4'b1000);
        @(negedge clk);
        drive(1'b0, 32'h0, 32'h0, 32'h0, 4'b0000);
        @(negedge clk);
        check("R2 high half ignored", out_result, 32'h00000008);

        done = 1'b1;
        summary();
        $finish;
    end
endmodule